// File: doc/BRIEF.md
# Receive Byte Queue with Programmable Fill Level

This block holds the bytes that a serial bus engine delivers on the receive side until the host gets around to reading them. The engine presents one byte at a time on a push strobe. The host removes one byte each time it reads the data port. The popped byte appears on a registered output and stays there until the next successful pop.

The host writes a zero-based level value. A level event is raised while the queue holds more bytes than that value, so a value of N means the event is present with N+1 or more bytes stored. The event lets the host service the queue in bursts rather than byte by byte. An occupancy output also reads zero-based: it gives the number of stored bytes minus one. Separate flags report an empty queue, a physically full queue, and a sticky overflow. Latching and masking of the event belong to an interrupt controller outside this block.

Top module: `rx_fifo_thresh`

## Requirements
- R1: After reset the queue is empty. `rx_empty` is 1 and `rx_full`, `rx_level_evt` and `rx_overflow` are 0. `occupancy` reads 0, `pop_data` reads 0 and `thresh_rd` reads DEPTH-1 (15).
- R2: Bytes leave in the order in which they arrived. A pop with the queue non-empty places the oldest byte on `pop_data` at that clock edge.
- R3: `occupancy` equals the number of stored bytes minus one, and reads 0 when the queue is empty.
- R4: `rx_empty` is 1 exactly when no byte is stored. `rx_full` is 1 exactly when DEPTH (16) bytes are stored.
- R5: `rx_level_evt` is a level, not a pulse. It is 1 whenever the stored count is at least `thresh_rd`+1, and 0 otherwise.
- R6: A write of `thresh_wdata` with `thresh_we` high takes effect at the next edge, in any state of the queue. It reads back on `thresh_rd`, and the level event re-evaluates against the new value in the same cycle.
- R7: A push while the queue is full and no pop is taken in the same cycle is discarded. Stored bytes and occupancy stay as they were. `rx_overflow` becomes 1 and stays 1 until reset.
- R8: A pop while the queue is empty leaves `pop_data` holding its previous value. The read and write positions do not change.
- R9: A push and a pop in the same cycle on a non-empty queue keep the occupancy unchanged. On a full queue the pushed byte is accepted, and no overflow is flagged.
- R10: Ordering is preserved after the read and write positions wrap past the end of storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Engine offers a received byte |
| push_data | input | DATA_W (8) | Received byte |
| pop_req | input | 1 | Host read of the data port |
| pop_data | output | DATA_W (8) | Most recently popped byte |
| thresh_we | input | 1 | Write strobe for the level value |
| thresh_wdata | input | AW (4) | New zero-based level value |
| thresh_rd | output | AW (4) | Current level value |
| occupancy | output | AW (4) | Stored bytes minus one (0 when empty) |
| rx_empty | output | 1 | No byte stored |
| rx_full | output | 1 | DEPTH bytes stored |
| rx_level_evt | output | 1 | Stored count exceeds the level value |
| rx_overflow | output | 1 | Sticky: a push was dropped |

## Verification
The hardest case to reach from the ports is a push and a pop in the same cycle against a full queue. The byte must be accepted because the pop frees a slot, and the sticky overflow must stay clear. The bench reaches this case before any overflow has ever been provoked. It fills all sixteen slots, then raises both strobes together. It then drains the queue to confirm that the new byte sits behind the original fifteen. The deliberate overflow runs last, because its flag cannot be cleared without reset.

// File: rtl/rx_fifo_thresh_pkg.sv
`timescale 1ns/1ps
package rx_fifo_thresh_pkg;

   typedef struct packed {
      logic empty;
      logic full;
      logic overflow;
   } rxf_flags_t;

endpackage

// File: rtl/rxf_ptr_ctl.sv
`timescale 1ns/1ps
module rxf_ptr_ctl
   import rx_fifo_thresh_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_valid,
   input  logic          pop_req,
   output logic          wr_en,
   output logic          rd_en,
   output logic [AW-1:0] wr_ptr,
   output logic [AW-1:0] rd_ptr,
   output logic [CW-1:0] count,
   output rxf_flags_t    flags
);

   logic [AW-1:0] wr_ptr_q, rd_ptr_q;
   logic [CW-1:0] count_q;
   logic          ovf_q;
   logic          is_empty, is_full;

   assign is_empty = (count_q == '0);
   assign is_full  = (count_q == CW'(DEPTH));

   assign rd_en = pop_req & ~is_empty;
   assign wr_en = push_valid & (~is_full | rd_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
         ovf_q    <= 1'b0;
      end else begin
         if (wr_en) wr_ptr_q <= wr_ptr_q + AW'(1);
         if (rd_en) rd_ptr_q <= rd_ptr_q + AW'(1);
         case ({wr_en, rd_en})
            2'b10:   count_q <= count_q + CW'(1);
            2'b01:   count_q <= count_q - CW'(1);
            default: count_q <= count_q;
         endcase
         if (push_valid && !wr_en) ovf_q <= 1'b1;
      end
   end

   assign wr_ptr         = wr_ptr_q;
   assign rd_ptr         = rd_ptr_q;
   assign count          = count_q;
   assign flags.empty    = is_empty;
   assign flags.full     = is_full;
   assign flags.overflow = ovf_q;

endmodule

// File: rtl/rxf_store.sv
`timescale 1ns/1ps
module rxf_store #(
   parameter int DATA_W        = 8,
   parameter int DEPTH         = 16,
   parameter bit RESET_STORAGE = 1'b1,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_ptr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_ptr,
   output logic [DATA_W-1:0] rd_data
);

   logic [DEPTH*DATA_W-1:0] flat;
   logic [DATA_W-1:0]       dout_q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [DATA_W-1:0] ent_q;
      logic              sel;
      assign sel = wr_en && (wr_ptr == AW'(i));
      if (RESET_STORAGE) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ent_q <= '0;
            else if (sel) ent_q <= wr_data;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (sel) ent_q <= wr_data;
         end
      end
      assign flat[i*DATA_W +: DATA_W] = ent_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dout_q <= '0;
      else if (rd_en) dout_q <= flat[rd_ptr*DATA_W +: DATA_W];
   end

   assign rd_data = dout_q;

endmodule

// File: rtl/rxf_level.sv
`timescale 1ns/1ps
module rxf_level #(
   parameter int DEPTH       = 16,
   parameter int THRESH_INIT = DEPTH - 1,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          thresh_we,
   input  logic [AW-1:0] thresh_wdata,
   input  logic [CW-1:0] count,
   output logic [AW-1:0] thresh_q,
   output logic [AW-1:0] occupancy,
   output logic          level_evt
);

   logic [CW-1:0] count_m1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         thresh_q <= AW'(THRESH_INIT);
      else if (thresh_we) thresh_q <= thresh_wdata;
   end

   assign count_m1  = count - CW'(1);
   assign occupancy = (count == '0) ? '0 : count_m1[AW-1:0];
   assign level_evt = (count > CW'(thresh_q));

endmodule

// File: rtl/rx_fifo_thresh.sv
`timescale 1ns/1ps
module rx_fifo_thresh
   import rx_fifo_thresh_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int DEPTH         = 16,
   parameter int THRESH_INIT   = DEPTH - 1,
   parameter bit RESET_STORAGE = 1'b1,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_valid,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop_req,
   output logic [DATA_W-1:0] pop_data,
   input  logic              thresh_we,
   input  logic [AW-1:0]     thresh_wdata,
   output logic [AW-1:0]     thresh_rd,
   output logic [AW-1:0]     occupancy,
   output logic              rx_empty,
   output logic              rx_full,
   output logic              rx_level_evt,
   output logic              rx_overflow
);

   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end
   if (THRESH_INIT < 0 || THRESH_INIT > DEPTH - 1) begin : g_bad_thresh
      $error("THRESH_INIT must lie in 0..DEPTH-1");
   end

   logic          wr_en, rd_en;
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;
   rxf_flags_t    flags;

   rxf_ptr_ctl #(.DEPTH(DEPTH)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (push_valid),
      .pop_req    (pop_req),
      .wr_en      (wr_en),
      .rd_en      (rd_en),
      .wr_ptr     (wr_ptr),
      .rd_ptr     (rd_ptr),
      .count      (count),
      .flags      (flags)
   );

   rxf_store #(
      .DATA_W        (DATA_W),
      .DEPTH         (DEPTH),
      .RESET_STORAGE (RESET_STORAGE)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_ptr  (wr_ptr),
      .wr_data (push_data),
      .rd_en   (rd_en),
      .rd_ptr  (rd_ptr),
      .rd_data (pop_data)
   );

   rxf_level #(
      .DEPTH       (DEPTH),
      .THRESH_INIT (THRESH_INIT)
   ) u_level (
      .clk          (clk),
      .rst_n        (rst_n),
      .thresh_we    (thresh_we),
      .thresh_wdata (thresh_wdata),
      .count        (count),
      .thresh_q     (thresh_rd),
      .occupancy    (occupancy),
      .level_evt    (rx_level_evt)
   );

   assign rx_empty    = flags.empty;
   assign rx_full     = flags.full;
   assign rx_overflow = flags.overflow;

endmodule

// File: rtl/rx_fifo_thresh_chk.sv
`timescale 1ns/1ps
module rx_fifo_thresh_chk #(
   parameter int DATA_W = 8,
   parameter int AW     = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push_valid,
   input logic              pop_req,
   input logic [DATA_W-1:0] pop_data,
   input logic              thresh_we,
   input logic [AW-1:0]     thresh_wdata,
   input logic [AW-1:0]     thresh_rd,
   input logic [AW-1:0]     occupancy,
   input logic              rx_empty,
   input logic              rx_full,
   input logic              rx_level_evt,
   input logic              rx_overflow
);

   AST_EMPTY_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_empty && rx_full)); // R4

   AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overflow |=> rx_overflow); // R7

   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && rx_full && !pop_req) |=> (rx_full && rx_overflow)); // R7

   AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && rx_empty) |=> $stable(pop_data)); // R8

   AST_OCC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && !pop_req && !rx_full && !rx_empty)
         |=> (occupancy == $past(occupancy) + AW'(1))); // R3

   AST_BOTH_KEEP_OCC: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && pop_req && !rx_empty) |=> $stable(occupancy)); // R9

   AST_EVT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      rx_level_evt == (!rx_empty && occupancy >= thresh_rd)); // R5

   AST_THRESH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      thresh_we |=> (thresh_rd == $past(thresh_wdata))); // R6

endmodule

bind rx_fifo_thresh rx_fifo_thresh_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .push_valid   (push_valid),
   .pop_req      (pop_req),
   .pop_data     (pop_data),
   .thresh_we    (thresh_we),
   .thresh_wdata (thresh_wdata),
   .thresh_rd    (thresh_rd),
   .occupancy    (occupancy),
   .rx_empty     (rx_empty),
   .rx_full      (rx_full),
   .rx_level_evt (rx_level_evt),
   .rx_overflow  (rx_overflow)
);

// File: tb/sim_rx_fifo_thresh.sv
`timescale 1ns/1ps
module sim_rx_fifo_thresh;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       push_valid = 1'b0;
   logic [7:0] push_data = '0;
   logic       pop_req = 1'b0;
   logic [7:0] pop_data;
   logic       thresh_we = 1'b0;
   logic [3:0] thresh_wdata = '0;
   logic [3:0] thresh_rd, occupancy;
   logic       rx_empty, rx_full, rx_level_evt, rx_overflow;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [7:0] model[$];

   always #2.5 clk = ~clk;

   rx_fifo_thresh u0 (
      .clk(clk), .rst_n(rst_n),
      .push_valid(push_valid), .push_data(push_data),
      .pop_req(pop_req), .pop_data(pop_data),
      .thresh_we(thresh_we), .thresh_wdata(thresh_wdata),
      .thresh_rd(thresh_rd), .occupancy(occupancy),
      .rx_empty(rx_empty), .rx_full(rx_full),
      .rx_level_evt(rx_level_evt), .rx_overflow(rx_overflow)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_eq(input string tag, input int act, input int exp);
      chk(act == exp, tag, act, exp);
   endtask

   function automatic int exp_occ();
      return (model.size() == 0) ? 0 : model.size() - 1;
   endfunction

   task automatic push_b(input logic [7:0] b);
      push_valid = 1'b1; push_data = b;
      step();
      push_valid = 1'b0;
      if (model.size() < 16) model.push_back(b);
   endtask

   task automatic pop_chk(input string tag);
      logic [7:0] e;
      pop_req = 1'b1;
      step();
      pop_req = 1'b0;
      if (model.size() > 0) begin
         e = model.pop_front();
         chk_eq(tag, pop_data, e);
      end
   endtask

   task automatic set_thresh(input logic [3:0] v);
      thresh_we = 1'b1; thresh_wdata = v;
      step();
      thresh_we = 1'b0;
   endtask

   task automatic drain(input string tag);
      while (model.size() > 0) pop_chk(tag);
   endtask

   task automatic t_reset();
      chk_eq("R1 empty", rx_empty, 1);
      chk_eq("R1 full", rx_full, 0);
      chk_eq("R1 evt", rx_level_evt, 0);
      chk_eq("R1 ovf", rx_overflow, 0);
      chk_eq("R1 occ", occupancy, 0);
      chk_eq("R1 thresh", thresh_rd, 15);
      chk_eq("R1 data", pop_data, 0);
   endtask

   task automatic t_order();
      for (int i = 0; i < 5; i++) push_b(8'h10 + 8'(i));
      chk_eq("R3 occ after 5", occupancy, 4);
      chk_eq("R4 not empty", rx_empty, 0);
      chk_eq("R4 not full", rx_full, 0);
      drain("R2 order");
      chk_eq("R4 empty again", rx_empty, 1);
      chk_eq("R3 occ empty", occupancy, 0);
   endtask

   task automatic t_thresh();
      set_thresh(4'd3);
      chk_eq("R6 readback", thresh_rd, 3);
      for (int i = 0; i < 3; i++) push_b(8'h20 + 8'(i));
      chk_eq("R5 evt below", rx_level_evt, 0);
      push_b(8'h23);
      chk_eq("R5 evt at level", rx_level_evt, 1);
      step();
      chk_eq("R5 evt holds", rx_level_evt, 1);
      set_thresh(4'd5);
      chk_eq("R6 raise clears evt", rx_level_evt, 0);
      set_thresh(4'd2);
      chk_eq("R6 lower sets evt", rx_level_evt, 1);
      pop_chk("R2 pop");
      chk_eq("R5 evt after pop", rx_level_evt, 1);
      pop_chk("R2 pop");
      chk_eq("R5 evt drop below", rx_level_evt, 0);
      drain("R2 drain");
      set_thresh(4'd0);
      push_b(8'h2A);
      chk_eq("R5 evt thresh0 one byte", rx_level_evt, 1);
      drain("R2 drain");
      chk_eq("R5 evt empty", rx_level_evt, 0);
      set_thresh(4'd15);
      chk_eq("R6 restore", thresh_rd, 15);
   endtask

   task automatic t_empty_pop();
      logic [7:0] last;
      push_b(8'h5C);
      pop_chk("R2 single");
      last = pop_data;
      pop_req = 1'b1; step(); pop_req = 1'b0;
      chk_eq("R8 data held", pop_data, last);
      chk_eq("R8 still empty", rx_empty, 1);
      chk_eq("R8 occ", occupancy, 0);
      push_b(8'h6D);
      chk_eq("R8 occ after push", occupancy, 0);
      chk_eq("R8 nonempty", rx_empty, 0);
      pop_chk("R8 pointers intact");
   endtask

   task automatic t_simul();
      logic [7:0] e;
      push_b(8'h70); push_b(8'h71);
      push_valid = 1'b1; push_data = 8'h72; pop_req = 1'b1;
      step();
      push_valid = 1'b0; pop_req = 1'b0;
      e = model.pop_front(); model.push_back(8'h72);
      chk_eq("R9 pop value", pop_data, e);
      chk_eq("R9 occ kept", occupancy, 1);
      drain("R9 order");
      for (int i = 0; i < 16; i++) push_b(8'h80 + 8'(i));
      chk_eq("R4 full", rx_full, 1);
      chk_eq("R3 occ full", occupancy, 15);
      chk_eq("R5 evt full", rx_level_evt, 1);
      push_valid = 1'b1; push_data = 8'hA5; pop_req = 1'b1;
      step();
      push_valid = 1'b0; pop_req = 1'b0;
      e = model.pop_front(); model.push_back(8'hA5);
      chk_eq("R9 pop on full", pop_data, e);
      chk_eq("R9 full kept", rx_full, 1);
      chk_eq("R9 no overflow", rx_overflow, 0);
      drain("R9 accepted byte order");
   endtask

   task automatic t_wrap();
      for (int r = 0; r < 3; r++) begin
         for (int i = 0; i < 11; i++) push_b(8'(r * 16 + i + 3));
         chk_eq("R10 occ", occupancy, 10);
         drain("R10 wrap order");
      end
   endtask

   task automatic t_overflow();
      for (int i = 0; i < 16; i++) push_b(8'hC0 + 8'(i));
      push_b(8'hEE);
      chk_eq("R7 occ unchanged", occupancy, 15);
      chk_eq("R7 overflow set", rx_overflow, 1);
      drain("R7 contents intact");
      chk_eq("R7 sticky", rx_overflow, 1);
      chk_eq("R7 empty after drain", rx_empty, 1);
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_order();
      t_thresh();
      t_empty_pop();
      t_simul();
      t_wrap();
      t_overflow();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule